// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers up to 32 external interrupt pins into one processor interrupt. Each pin first passes a two-stage synchroniser. It is then watched for a falling edge, a rising edge, a high level or a low level, chosen per line by software. A detected event sets a sticky status bit. A line counts as pending when its status bit and its enable bit are both set, and the interrupt output is the OR of all pending lines.

Software reaches the block through a simple 32-bit register port. Writes take effect on the clock edge and reads are combinational. The enable bits use separate set and clear registers, and status bits are cleared by writing ones. A test register can replace the synchronised pins with a value that software writes. A control bit routes line 0 to a separate non-maskable output that ignores the enable mask. The number of implemented lines is a parameter, and configuration bits for absent lines read as zero.

Top module: `extint_unit`

## Requirements
- R1: After reset every register reads zero, and both `irqOut` and `nmiOut` are low.
- R2: Writing to byte offset 0x00 sets each enable bit whose data bit is 1. Writing to offset 0x04 clears each enable bit whose data bit is 1. Data bits written as 0 leave the enable bits unchanged. The enable bits read back at offset 0x08.
- R3: Writing to offset 0x10 clears each status bit whose data bit is 1, unless an event is detected on that line in the same cycle. The status reads at offset 0x0C.
- R4: Status bits latch whether or not the line is enabled. `irqOut` is high exactly when some line has both its status bit and its enable bit set.
- R5: The sense-select (0x14), edge-select (0x18) and level-select (0x1C) registers hold one bit per line. Bits at or above NUM_LINES cannot be set and read as 0, so writing all ones reads back 2^NUM_LINES-1.
- R6: With sense-select 0 and edge-select 0, a 1-to-0 change on a pin sets its status bit on the third rising clock edge after the change, and not before.
- R7: With sense-select 0 and edge-select 1, only a 0-to-1 change sets the status bit, and a 1-to-0 change does not.
- R8: With sense-select 1, the status bit is set on every cycle in which the line equals its level-select bit (1 = active-high, 0 = active-low). A clear has no lasting effect while the level stays active, and it does stick once the line goes inactive.
- R9: The test register at 0x20 has its enable flag at bit 31 and a value in bits [min(NUM_LINES,31)-1:0]. While the flag is set, the value replaces the synchronised pins as the detector input, so pin changes set no status bits. It reads back as written.
- R10: Bit 0 of the register at 0x24 is the non-maskable enable. While it is set, `nmiOut` follows status bit 0 whatever enable bit 0 holds. While it is clear, `nmiOut` is low.
- R11: The write-only offsets 0x00, 0x04 and 0x10, and any unmapped offset, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| extPins | input | NUM_LINES | External interrupt pins, asynchronous |
| irqOut | output | 1 | Combined interrupt for enabled, pending lines |
| nmiOut | output | 1 | Non-maskable interrupt from line 0 |

## Verification
The hardest case to reach is a clear that lands while a level-sensed line is still active, because the clear and the re-set happen on the same edge. The bench sets this up by selecting active-high sensing on a pin that is already high. It then issues a clear and checks that the bit survives, drops the pin, waits out the synchroniser and clears again. A second hard case is leaving test mode: the detector input jumps from the test value back to the real pins, which creates edges on several lines at once. A behavioural model that is stepped every clock predicts exactly which lines catch them.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Word indices (byte offset / 4) of the register map
  localparam int unsigned IDX_MASK_SET  = 0;
  localparam int unsigned IDX_MASK_CLR  = 1;
  localparam int unsigned IDX_MASK_RD   = 2;
  localparam int unsigned IDX_STATUS    = 3;
  localparam int unsigned IDX_STAT_CLR  = 4;
  localparam int unsigned IDX_SENSE     = 5;
  localparam int unsigned IDX_EDGESEL   = 6;
  localparam int unsigned IDX_LEVELSEL  = 7;
  localparam int unsigned IDX_TEST      = 8;
  localparam int unsigned IDX_NMICTL    = 9;

  localparam int unsigned REG_W       = 32;
  localparam int unsigned TEST_EN_BIT = 31;

  // Write strobes from control to datapath
  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic statusClr;
    logic senseWr;
    logic edgeSelWr;
    logic levelSelWr;
    logic testWr;
    logic nmiWr;
  } strobeT;

  // Read selects from control to datapath
  typedef struct packed {
    logic selMask;
    logic selStatus;
    logic selSense;
    logic selEdge;
    logic selLevel;
    logic selTest;
    logic selNmi;
  } rdSelT;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobeT            strb,
  output rdSelT             rdSel
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             unusedByteLane;

  assign wordIdx        = regAddr[ADDR_W-1:2];
  assign unusedByteLane = ^regAddr[1:0];

  function automatic logic hit(input int unsigned idx);
    return wordIdx == IDX_W'(idx);
  endfunction

  always_comb begin
    strb            = '0;
    strb.maskSet    = regWrEn && hit(IDX_MASK_SET);
    strb.maskClr    = regWrEn && hit(IDX_MASK_CLR);
    strb.statusClr  = regWrEn && hit(IDX_STAT_CLR);
    strb.senseWr    = regWrEn && hit(IDX_SENSE);
    strb.edgeSelWr  = regWrEn && hit(IDX_EDGESEL);
    strb.levelSelWr = regWrEn && hit(IDX_LEVELSEL);
    strb.testWr     = regWrEn && hit(IDX_TEST);
    strb.nmiWr      = regWrEn && hit(IDX_NMICTL);
  end

  always_comb begin
    rdSel           = '0;
    rdSel.selMask   = hit(IDX_MASK_RD);
    rdSel.selStatus = hit(IDX_STATUS);
    rdSel.selSense  = hit(IDX_SENSE);
    rdSel.selEdge   = hit(IDX_EDGESEL);
    rdSel.selLevel  = hit(IDX_LEVELSEL);
    rdSel.selTest   = hit(IDX_TEST);
    rdSel.selNmi    = hit(IDX_NMICTL);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R2

  AST_ONE_RDSEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdSel)); // R11

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] extPins,
  input  strobeT               strb,
  input  rdSelT                rdSel,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  output logic                 irqOut,
  output logic                 nmiOut
);

  localparam int unsigned N    = NUM_LINES;
  localparam int unsigned TV_W = (N < REG_W) ? N : REG_W - 1;
  localparam logic [N-1:0] TEST_MASK = N'((64'd1 << TV_W) - 64'd1);

  logic [N-1:0] syncA, syncB, prevQ;
  logic [N-1:0] maskQ, statusQ, senseQ, edgeSelQ, levelSelQ, testValQ;
  logic         testEnQ, nmiEnQ;
  logic [N-1:0] detIn, eventVec, lineWr, clrVec;
  logic         unusedWrBits;

  assign lineWr       = wrData[N-1:0];
  assign clrVec       = strb.statusClr ? lineWr : '0;
  assign unusedWrBits = ^wrData;

  // Input synchroniser, two flops per line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= extPins;
      syncB <= syncA;
    end
  end

  assign detIn = testEnQ ? testValQ : syncB;

  // Per-line event detection
  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      if (senseQ[i])
        eventVec[i] = (detIn[i] == levelSelQ[i]);
      else if (edgeSelQ[i])
        eventVec[i] = detIn[i] && !prevQ[i];
      else
        eventVec[i] = !detIn[i] && prevQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ     <= '0;
      maskQ     <= '0;
      statusQ   <= '0;
      senseQ    <= '0;
      edgeSelQ  <= '0;
      levelSelQ <= '0;
      testValQ  <= '0;
      testEnQ   <= 1'b0;
      nmiEnQ    <= 1'b0;
    end else begin
      prevQ   <= detIn;
      statusQ <= (statusQ & ~clrVec) | eventVec;
      if (strb.maskSet)
        maskQ <= maskQ | lineWr;
      else if (strb.maskClr)
        maskQ <= maskQ & ~lineWr;
      if (strb.senseWr)    senseQ    <= lineWr;
      if (strb.edgeSelWr)  edgeSelQ  <= lineWr;
      if (strb.levelSelWr) levelSelQ <= lineWr;
      if (strb.testWr) begin
        testValQ <= lineWr & TEST_MASK;
        testEnQ  <= wrData[TEST_EN_BIT];
      end
      if (strb.nmiWr) nmiEnQ <= wrData[0];
    end
  end

  assign irqOut = |(statusQ & maskQ);
  assign nmiOut = nmiEnQ && statusQ[0];

  // Read mux, AND-OR over one-hot selects
  always_comb begin
    logic [REG_W-1:0] testWord;
    testWord              = REG_W'(testValQ);
    testWord[TEST_EN_BIT] = testEnQ;
    rdData = ({REG_W{rdSel.selMask}}   & REG_W'(maskQ))
           | ({REG_W{rdSel.selStatus}} & REG_W'(statusQ))
           | ({REG_W{rdSel.selSense}}  & REG_W'(senseQ))
           | ({REG_W{rdSel.selEdge}}   & REG_W'(edgeSelQ))
           | ({REG_W{rdSel.selLevel}}  & REG_W'(levelSelQ))
           | ({REG_W{rdSel.selTest}}   & testWord)
           | ({REG_W{rdSel.selNmi}}    & REG_W'(nmiEnQ));
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskSet |=> ((maskQ & $past(lineWr)) == $past(lineWr))); // R2

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.maskClr |=> ((maskQ & $past(lineWr)) == '0)); // R2

  AST_STATUS_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.statusClr |=> ((statusQ & $past(lineWr & ~eventVec)) == '0)); // R3

  AST_STATUS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(eventVec)) == '0)); // R6

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskQ != '0)); // R4

endmodule

// File: rtl/extint_unit.sv
module extint_unit
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] extPins,
  output logic                 irqOut,
  output logic                 nmiOut
);

  strobeT strb;
  rdSelT  rdSel;

  initial begin
    AST_PARAM_RANGE: assert (NUM_LINES >= 1 && NUM_LINES <= 32 && ADDR_W >= 6); // R5
  end

  extint_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  extint_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .extPins (extPins),
    .strb    (strb),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .nmiOut  (nmiOut)
  );

endmodule

// File: tb/tb_extint_unit.sv
module tb_extint_unit;

  localparam int N  = 8;
  localparam int AW = 6;
  localparam time HALF = 10ns;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] regAddr;
  logic          regWrEn;
  logic [31:0]   regWrData;
  logic [31:0]   regRdData;
  logic [N-1:0]  extPins;
  logic          irqOut, nmiOut;

  int checks = 0;
  int errors = 0;

  always #HALF clk = ~clk;

  extint_unit #(.NUM_LINES(N), .ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .extPins(extPins),
    .irqOut(irqOut), .nmiOut(nmiOut)
  );

  // Behavioural reference state
  logic [N-1:0] mS1, mS2, mPrev, mMask, mStat, mSense, mEdge, mLevel, mTval;
  logic         mTen, mNmi;

  function automatic logic [31:0] modelRead(input logic [AW-1:0] a);
    case (int'(a) / 4)
      2: return 32'(mMask);
      3: return 32'(mStat);
      5: return 32'(mSense);
      6: return 32'(mEdge);
      7: return 32'(mLevel);
      8: return {mTen, 23'd0, mTval};
      9: return {31'd0, mNmi};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: advance model, then compare at the falling edge
  task automatic cyc();
    logic [N-1:0] det, ev, nStat, nMask, d;
    int w;
    d = regWrData[N-1:0];
    w = int'(regAddr) / 4;
    det = mTen ? mTval : mS2;
    for (int i = 0; i < N; i++) begin
      if (mSense[i]) ev[i] = (det[i] == mLevel[i]);
      else if (mEdge[i]) ev[i] = det[i] && !mPrev[i];
      else ev[i] = !det[i] && mPrev[i];
    end
    nStat = mStat;
    nMask = mMask;
    if (regWrEn && w == 4) nStat = nStat & ~d;
    nStat = nStat | ev;
    if (regWrEn && w == 0) nMask = nMask | d;
    if (regWrEn && w == 1) nMask = nMask & ~d;
    @(posedge clk);
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mMask = '0; mStat = '0;
      mSense = '0; mEdge = '0; mLevel = '0; mTval = '0; mTen = 0; mNmi = 0;
    end else begin
      if (regWrEn && w == 5) mSense = d;
      if (regWrEn && w == 6) mEdge = d;
      if (regWrEn && w == 7) mLevel = d;
      if (regWrEn && w == 8) begin mTval = d; mTen = regWrData[31]; end
      if (regWrEn && w == 9) mNmi = regWrData[0];
      mS2 = mS1; mS1 = extPins; mPrev = det; mStat = nStat; mMask = nMask;
    end
    @(negedge clk);
    chk("MODEL irqOut R4", 32'(irqOut), 32'(|(mStat & mMask)));
    chk("MODEL nmiOut R10", 32'(nmiOut), 32'(mNmi & mStat[0]));
    chk("MODEL rdData", regRdData, modelRead(regAddr));
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    regAddr = AW'(a); regWrData = v; regWrEn = 1'b1;
    cyc();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    regAddr = AW'(a);
    #1;
    chk(tag, regRdData, exp);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0; extPins = '1;
    mS1 = '0; mS2 = '0; mPrev = '0; mMask = '0; mStat = '0;
    mSense = '0; mEdge = '0; mLevel = '0; mTval = '0; mTen = 0; mNmi = 0;
    @(negedge clk);
    waitN(3);
    rstN = 1'b1;
    waitN(4);

    // R1 reset state
    for (int a = 0; a < 40; a += 4) rd(a, 32'd0, "R1 reset read");
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 nmiOut", 32'(nmiOut), 0);

    // R5 implemented bits
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, 32'h0000_00FF, "R5 sense all ones");
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 32'h0000_00FF, "R5 edge all ones");
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h0000_00FF, "R5 level all ones");
    wr(8'h14, 0); wr(8'h18, 0); wr(8'h1C, 0);
    waitN(3);
    wr(8'h10, 32'hFF); waitN(1);
    rd(8'h0C, 0, "R5 status clean");

    // R2 mask set / clear
    wr(8'h00, 32'h05); rd(8'h08, 32'h05, "R2 set");
    wr(8'h00, 32'h02); rd(8'h08, 32'h07, "R2 set more");
    wr(8'h04, 32'h01); rd(8'h08, 32'h06, "R2 clear");
    wr(8'h04, 32'h00); rd(8'h08, 32'h06, "R2 zero no effect");

    // R6 falling edge latency
    extPins[1] = 1'b0;
    waitN(2); rd(8'h0C, 0, "R6 not before third edge");
    waitN(1); rd(8'h0C, 32'h02, "R6 set on third edge");
    chk("R6 irqOut", 32'(irqOut), 1);

    // R3 status clear
    wr(8'h10, 32'h02); rd(8'h0C, 0, "R3 cleared");
    chk("R3 irqOut low", 32'(irqOut), 0);

    // R4 masked line latches, no irq until enabled
    extPins[0] = 1'b0; waitN(3);
    rd(8'h0C, 32'h01, "R4 latched while masked");
    chk("R4 irq masked", 32'(irqOut), 0);
    wr(8'h00, 32'h01); chk("R4 irq after enable", 32'(irqOut), 1);
    wr(8'h10, 32'h01); chk("R4 irq after clear", 32'(irqOut), 0);
    extPins[1:0] = 2'b11; waitN(4);
    rd(8'h0C, 0, "R6 rising ignored in falling mode");

    // R7 rising edge selection
    wr(8'h18, 32'h04);
    extPins[2] = 1'b0; waitN(4); rd(8'h0C, 0, "R7 falling ignored");
    extPins[2] = 1'b1; waitN(4); rd(8'h0C, 32'h04, "R7 rising caught");
    wr(8'h10, 32'h04);

    // R8 level sensing
    wr(8'h1C, 32'h08); wr(8'h14, 32'h08); waitN(1);
    rd(8'h0C, 32'h08, "R8 active high sets");
    wr(8'h10, 32'h08); rd(8'h0C, 32'h08, "R8 clear while active");
    extPins[3] = 1'b0; waitN(4);
    wr(8'h10, 32'h08); waitN(3); rd(8'h0C, 0, "R8 clear sticks when inactive");
    wr(8'h14, 0); waitN(2);
    extPins[3] = 1'b1; waitN(4);
    rd(8'h0C, 0, "R8 back to edge");

    // R9 test override
    wr(8'h20, 32'h8000_00FF); waitN(2);
    rd(8'h0C, 0, "R9 same value no event");
    extPins[4] = 1'b0; waitN(4);
    rd(8'h0C, 0, "R9 pins ignored");
    wr(8'h20, 32'h8000_00F0); waitN(1);
    rd(8'h0C, 32'h0B, "R9 test value edges");
    rd(8'h20, 32'h8000_00F0, "R9 readback");
    wr(8'h10, 32'hFF);
    wr(8'h20, 0); waitN(2);
    extPins[4] = 1'b1; waitN(4);
    wr(8'h10, 32'hFF); waitN(1);
    rd(8'h0C, 0, "R9 clean after exit");

    // R10 non-maskable output
    wr(8'h04, 32'hFF);
    wr(8'h24, 32'h1);
    rd(8'h24, 32'h1, "R10 readback");
    extPins[0] = 1'b0; waitN(4);
    chk("R10 nmi ignores mask", 32'(nmiOut), 1);
    chk("R10 irq masked", 32'(irqOut), 0);
    wr(8'h24, 32'h0);
    chk("R10 nmi disabled", 32'(nmiOut), 0);
    extPins[0] = 1'b1; waitN(4);
    wr(8'h10, 32'hFF);

    // R11 write-only and unmapped reads
    wr(8'h00, 32'h10);
    rd(8'h00, 0, "R11 set reg reads zero");
    rd(8'h04, 0, "R11 clear reg reads zero");
    rd(8'h10, 0, "R11 status clear reads zero");
    rd(8'h28, 0, "R11 unmapped");
    rd(8'h3C, 0, "R11 unmapped top");
    waitN(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule